// File: doc/BRIEF.md
# Polled Wake-Port Controller

This block watches a set of external wake inputs and latches a status bit for each one. The status bits are ORed into a collective interrupt and a wake-up request. Each port has its own enable and its own trigger select. In edge mode a port fires on a rising edge of its synchronised input. In level mode a port fires only when its input is high during a sampling strobe.

The strobe comes from a polling engine that runs on a poll-clock enable pulse (`poll_tick`). At the start of each poll period the engine raises `poll_out`, which can power an external sensor. After a selectable number of poll ticks it emits a one-cycle `poll_strobe` and drops `poll_out`. A sensor therefore only draws current for a short window in each period. Software clears status bits by writing ones to them.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wake_poll_ctrl`

## Requirements
- R1: After reset, `wake_status`, `irq`, `wake_req`, `poll_out` and `poll_strobe` are all 0.
- R2: A port whose `port_en` bit is 0 never sets its status bit, whatever its input does.
- R3: An enabled port with `port_level`=0 (edge mode) sets its status bit on a rising edge of its input. The input passes two synchroniser flops. The status bit is high after the third clock edge that samples the input high. An input that stays high does not set the bit again.
- R4: An enabled port with `port_level`=1 (level mode) sets its status bit only when its synchronised input is 1 in the cycle where `poll_strobe` is 1. The bit is high at the next clock edge.
- R5: `irq` and `wake_req` are both 1 exactly when at least one status bit is 1.
- R6: A cycle with `clr_wr`=1 clears every status bit whose `clr_data` bit is 1. If a set event hits the same bit in that cycle, the bit is set instead.
- R7: While `poll_en`=1, a period counter advances on each `poll_tick` and wraps after P ticks. `per_sel` values 0 to 5 give P = 1, 2, 4, 8, 16 and 32, and any larger value gives 32. A tick that finds the counter at 0 starts a period and raises `poll_out` at that edge.
- R8: `dly_sel` values 0 to 5 give a delay D = 1, 2, 4, 8, 16 and 24 ticks, and any larger value gives 24. On the D-th tick after a period start, `poll_strobe` is high for one clock and `poll_out` falls at the same edge. `poll_strobe` is never high except in the clock that follows a tick.
- R9: If a period starts on the tick that completes the delay, `poll_out` stays high and a new delay begins. If a period starts before the delay completes, the delay restarts and no strobe is issued for the earlier start.
- R10: While `poll_en`=0, the engine is held idle: the counters are at 0 and `poll_out` and `poll_strobe` are 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_in | input | NUM_PORTS | External wake inputs (asynchronous) |
| port_en | input | NUM_PORTS | Per-port enable |
| port_level | input | NUM_PORTS | Per-port trigger select: 0 edge, 1 level on strobe |
| poll_en | input | 1 | Polling engine enable |
| poll_tick | input | 1 | One-cycle poll-clock enable pulse |
| per_sel | input | 3 | Poll period select |
| dly_sel | input | 3 | Strobe delay select |
| clr_wr | input | 1 | Status clear write strobe |
| clr_data | input | NUM_PORTS | Write-one-to-clear mask |
| wake_status | output | NUM_PORTS | Latched per-port wake status |
| irq | output | 1 | Collective interrupt |
| wake_req | output | 1 | Wake-up request |
| poll_out | output | 1 | Sensor supply enable from the polling engine |
| poll_strobe | output | 1 | One-cycle level-sampling strobe |

## Verification
The bench targets several corner cases, and each has a visible failure mode when handled wrongly. If a period start coincides with delay completion, a wrong design shows a glitch or gap on `poll_out`. If a short period keeps restarting the delay, a wrong design emits strobes that should never appear. When a clear and a set hit the same bit, a wrong design drops a wake event. A level port held high outside the strobe should stay clear, and a wrong design sets it early. An edge port held high after a clear must not set again, and a wrong design sets it repeatedly. The bench also uses out-of-range selector codes, which should clamp to the longest period and delay, and drops `poll_en` in mid-period. A design that mishandled either would strobe at the wrong tick or leave `poll_out` stuck high.

// File: rtl/wake_poll_pkg.sv
package wake_poll_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 6;

  // period length in poll ticks; codes above the table clamp to the longest
  function automatic logic [CNT_W-1:0] period_len(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: period_len = 6'd1;
      3'd1: period_len = 6'd2;
      3'd2: period_len = 6'd4;
      3'd3: period_len = 6'd8;
      3'd4: period_len = 6'd16;
      default: period_len = 6'd32;
    endcase
  endfunction

  // ticks from period start to strobe
  function automatic logic [CNT_W-1:0] delay_len(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: delay_len = 6'd1;
      3'd1: delay_len = 6'd2;
      3'd2: delay_len = 6'd4;
      3'd3: delay_len = 6'd8;
      3'd4: delay_len = 6'd16;
      default: delay_len = 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/wake_poll_timer.sv
module wake_poll_timer
  import wake_poll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_en,
  input  logic             poll_tick,
  input  logic [SEL_W-1:0] per_sel,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             poll_out,
  output logic             poll_strobe
);
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] dly_cnt;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] dly_len;
  logic             at_start;
  logic             dly_done;

  always_comb begin
    per_len  = period_len(per_sel);
    dly_len  = delay_len(dly_sel);
    at_start = (per_cnt == '0);
    dly_done = poll_out && (dly_cnt == dly_len - 6'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt     <= '0;
      dly_cnt     <= '0;
      poll_out    <= 1'b0;
      poll_strobe <= 1'b0;
    end else if (!poll_en) begin
      per_cnt     <= '0;
      dly_cnt     <= '0;
      poll_out    <= 1'b0;
      poll_strobe <= 1'b0;
    end else begin
      poll_strobe <= 1'b0;
      if (poll_tick) begin
        poll_strobe <= dly_done;
        if (at_start) begin
          poll_out <= 1'b1;
          dly_cnt  <= '0;
        end else if (dly_done) begin
          poll_out <= 1'b0;
        end else if (poll_out) begin
          dly_cnt <= dly_cnt + 6'd1;
        end
        per_cnt <= (per_cnt >= per_len - 6'd1) ? '0 : per_cnt + 6'd1;
      end
    end
  end

  assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe |-> $past(poll_tick));
  assert_out_falls_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(poll_out) && $past(poll_en) |-> poll_strobe);
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> !poll_out && !poll_strobe);
endmodule

// File: rtl/wake_port_cell.sv
module wake_port_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  input  logic level_mode,
  input  logic strobe,
  output logic set_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[LAST];
    end
  end

  always_comb begin
    rise  = sync_q[LAST] & ~prev_q;
    set_o = en & (level_mode ? (strobe & sync_q[LAST]) : rise);
  end
endmodule

// File: rtl/wake_poll_ctrl.sv
module wake_poll_ctrl
  import wake_poll_pkg::*;
#(
  parameter int NUM_PORTS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] wake_in,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_level,
  input  logic                 poll_en,
  input  logic                 poll_tick,
  input  logic [SEL_W-1:0]     per_sel,
  input  logic [SEL_W-1:0]     dly_sel,
  input  logic                 clr_wr,
  input  logic [NUM_PORTS-1:0] clr_data,
  output logic [NUM_PORTS-1:0] wake_status,
  output logic                 irq,
  output logic                 wake_req,
  output logic                 poll_out,
  output logic                 poll_strobe
);
  logic [NUM_PORTS-1:0] set_vec;
  logic [NUM_PORTS-1:0] clr_mask;

  wake_poll_timer i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_en    (poll_en),
    .poll_tick  (poll_tick),
    .per_sel    (per_sel),
    .dly_sel    (dly_sel),
    .poll_out   (poll_out),
    .poll_strobe(poll_strobe)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    wake_port_cell #(.SYNC_STAGES(SYNC_STAGES)) i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (wake_in[p]),
      .en        (port_en[p]),
      .level_mode(port_level[p]),
      .strobe    (poll_strobe),
      .set_o     (set_vec[p])
    );
  end

  assign clr_mask = clr_wr ? clr_data : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_status <= '0;
    else        wake_status <= (wake_status & ~clr_mask) | set_vec;
  end

  always_comb begin
    irq      = |wake_status;
    wake_req = |wake_status;
  end

  assert_set_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_status & ~$past(wake_status) & ~$past(port_en)) == '0);
  assert_level_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_strobe |-> (set_vec & port_level) == '0);
  assert_clear_takes_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_status & $past(clr_mask & ~set_vec)) == '0);
  assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_status & ~$past(wake_status) & ~$past(set_vec)) == '0);
endmodule

// File: tb/test_wake_poll_ctrl.sv
module test_wake_poll_ctrl;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wake_in = '0, port_en = '0, port_level = '0, clr_data = '0;
  logic poll_en = 1'b0, poll_tick = 1'b0, clr_wr = 1'b0;
  logic [2:0] per_sel = '0, dly_sel = '0;
  logic [N-1:0] wake_status;
  logic irq, wake_req, poll_out, poll_strobe;

  int total = 0, bad = 0, tick_gap = 0, tick_cnt = 0, strobe_seen = 0;

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0, m_set;
  int m_pcnt = 0, m_dcnt = 0, m_p, m_d;
  bit m_pout = 0, m_strobe = 0, m_done, m_start;

  wake_poll_ctrl #(.NUM_PORTS(N)) i_wake_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .port_en(port_en),
    .port_level(port_level), .poll_en(poll_en), .poll_tick(poll_tick),
    .per_sel(per_sel), .dly_sel(dly_sel), .clr_wr(clr_wr), .clr_data(clr_data),
    .wake_status(wake_status), .irq(irq), .wake_req(wake_req),
    .poll_out(poll_out), .poll_strobe(poll_strobe));

  always #5 clk = ~clk;

  function automatic int per_of(input logic [2:0] s);
    return (s > 3'd5) ? 32 : (1 << s);
  endfunction
  function automatic int dly_of(input logic [2:0] s);
    return (s > 3'd4) ? 24 : (1 << s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    if (tick_gap == 0) poll_tick <= 1'b0;
    else begin
      tick_cnt <= tick_cnt + 1;
      poll_tick <= ((tick_cnt % tick_gap) == 0);
    end
  end

  // model update and per-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      m_pcnt = 0; m_dcnt = 0; m_pout = 0; m_strobe = 0;
    end else begin
      for (int i = 0; i < N; i++)
        m_set[i] = port_en[i] && (port_level[i] ? (m_strobe && m_s2[i]) : (m_s2[i] && !m_prev[i]));
      if (clr_wr) m_stat = m_stat & ~clr_data;
      m_stat = m_stat | m_set;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = wake_in;
      if (!poll_en) begin
        m_pcnt = 0; m_dcnt = 0; m_pout = 0; m_strobe = 0;
      end else begin
        m_strobe = 0;
        if (poll_tick) begin
          m_p = per_of(per_sel); m_d = dly_of(dly_sel);
          m_done = m_pout && (m_dcnt == m_d - 1);
          m_start = (m_pcnt == 0);
          if (m_done) begin m_strobe = 1; m_pout = 0; end
          if (m_start) begin m_pout = 1; m_dcnt = 0; end
          else if (m_pout) m_dcnt++;
          m_pcnt = (m_pcnt >= m_p - 1) ? 0 : m_pcnt + 1;
        end
      end
    end
    #1;
    if (rst_n) begin
      check("R2/R3/R4/R6 status", wake_status, m_stat);
      check("R5 irq", irq, |m_stat);
      check("R5 wake_req", wake_req, |m_stat);
      check("R7/R9/R10 poll_out", poll_out, m_pout);
      check("R8 poll_strobe", poll_strobe, m_strobe);
      if (poll_strobe) strobe_seen++;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear(input logic [N-1:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_data = m;
    @(negedge clk); clr_wr = 1'b0; clr_data = '0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 status", wake_status, '0);
    check("R1 irq", irq, 0);
    check("R1 poll_out", poll_out, 0);
    check("R1 poll_strobe", poll_strobe, 0);
    rst_n = 1'b1;
    port_en = 10'b01_1111_1111;
    port_level = 10'b01_1110_0000;
    cycles(2);
    // R3: edge port fires, R2: disabled port silent
    wake_in[0] = 1'b1; wake_in[9] = 1'b1;
    cycles(5);
    check("R3 edge sets", wake_status[0], 1);
    check("R2 disabled port", wake_status[9], 0);
    check("R5 irq on status", irq, 1);
    // R4: level port high with no polling stays clear
    wake_in[5] = 1'b1;
    cycles(20);
    check("R4 no strobe no set", wake_status[5], 0);
    clear('1);
    cycles(4);
    check("R6 clear all, held edge no reset", wake_status, '0);
    // polling on: level port catches on strobe
    tick_gap = 3; per_sel = 3'd2; dly_sel = 3'd1; poll_en = 1'b1;
    cycles(80);
    check("R4 strobe sets level port", wake_status[5], 1);
    // set-vs-clear contention, edge pulses with clear held
    for (int k = 0; k < 6; k++) begin
      wake_in[1] = ~wake_in[1]; wake_in[2] = (k % 3 == 0);
      clr_wr = 1'b1; clr_data = 10'b00_0010_0110;
      cycles(2);
    end
    clr_wr = 1'b0; clr_data = '0;
    cycles(10);
    // R9: short period restarts delay, no strobe
    tick_gap = 1; per_sel = 3'd0; dly_sel = 3'd3;
    cycles(5); strobe_seen = 0;
    cycles(40);
    check("R9 restart suppresses strobe", strobe_seen, 0);
    // R9: start on completion keeps poll_out high
    dly_sel = 3'd0;
    cycles(10);
    check("R9 poll_out held", poll_out, 1);
    check("R9 strobes issued", strobe_seen > 0, 1);
    // R7/R8 clamped selectors
    per_sel = 3'd7; dly_sel = 3'd6; tick_gap = 2;
    cycles(300);
    per_sel = 3'd5; dly_sel = 3'd4; wake_in[6] = 1'b1;
    cycles(200);
    // R10: drop enable mid-period
    poll_en = 1'b0;
    cycles(2);
    check("R10 poll_out idle", poll_out, 0);
    check("R10 poll_strobe idle", poll_strobe, 0);
    cycles(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule